// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive Queue and Error Requests

This block recovers characters from an asynchronous serial line. A divider produces a tick at sixteen times the bit rate. The receiver waits on an idle-high line for a low level, confirms it at mid-bit, and then samples each data bit at its centre, least significant bit first. An optional parity bit follows, then one or two stop bits. Each finished character is written into a small first-in first-out queue that the consumer drains through a show-ahead read port.

Four sticky flags record what went wrong: stop-bit error, parity error, queue overrun and line break. A character with a stop-bit or parity error is still queued. Writing is refused only when the queue is full, when an overrun is outstanding, or when a break is outstanding. Three level interrupt requests combine the flags with two enable inputs.

The frame sequencer has six states. IDLE moves to START on a low line sample. START returns to IDLE if the line is high at mid-bit (noise), and otherwise moves to DATA. DATA moves to PARITY after the last data bit when parity is on, and to STOP1 when it is off. PARITY moves to STOP1. STOP1 samples the stop bit, completes the character, and moves to STOP2 when two stop bits are selected, or to IDLE otherwise. STOP2 waits one bit time without checking the line and moves to IDLE.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the queue is empty and all flags and interrupt requests are 0.
- R2: With divider value D, an oversampling tick occurs every D+1 clocks and a bit lasts 16 ticks. Data bits arrive least significant bit first and are read back unchanged. The oldest entry appears on rd_data_o.
- R3: A low level that is gone by the middle of the start bit is ignored. No character is produced and no flag changes.
- R4: When parity is on, the expected parity bit is the XOR of the data bits, inverted when odd parity is selected. A mismatch sets parity_err_o, and the character is still queued.
- R5: A stop bit sampled as 0 sets framing_err_o, and the character is still queued.
- R6: With two stop bits selected, only the first is checked. A 0 in the second stop bit sets no flag.
- R7: A character that completes while the queue holds FIFO_DEPTH entries is discarded and sets overrun_o.
- R8: While overrun_o is 1, completed characters are discarded even when the queue has room. clr_ovr_i clears the flag.
- R9: A frame whose data, parity (if on) and stop bit are all 0 sets break_o and framing_err_o and is not queued. While break_o is 1, no character is queued. clr_brk_i clears the flag.
- R10: irq_rx_o is 1 exactly when rx_irq_en_i is 1 and either the queue count is at least RX_THRESH or the queue is not empty. data_ready_o shows a non-empty queue and thresh_o shows a count of at least RX_THRESH.
- R11: irq_err_o is 1 exactly when framing_err_o or parity_err_o is set and either enable input is 1.
- R12: irq_brk_o is 1 exactly when break_o or overrun_o is set and either enable input is 1.
- R13: A rd_en_i pulse removes one entry. A read on an empty queue changes nothing.
- R14: The stop-bit and parity error flags stay set until clr_err_i is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_div_i | input | DIV_W | Clocks per oversampling tick minus one |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | Odd parity when 1, even parity when 0 |
| two_stop_i | input | 1 | Two stop bits |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| rd_en_i | input | 1 | Remove the oldest queue entry |
| clr_err_i | input | 1 | Clear the stop-bit and parity error flags |
| clr_ovr_i | input | 1 | Clear the overrun flag |
| clr_brk_i | input | 1 | Clear the break flag |
| rd_data_o | output | DATA_W | Oldest queued character |
| fifo_count_o | output | $clog2(FIFO_DEPTH)+1 | Number of queued characters |
| data_ready_o | output | 1 | Queue not empty |
| thresh_o | output | 1 | Count at or above RX_THRESH |
| framing_err_o | output | 1 | Sticky stop-bit error |
| parity_err_o | output | 1 | Sticky parity error |
| overrun_o | output | 1 | Sticky overrun |
| break_o | output | 1 | Sticky line break |
| irq_rx_o | output | 1 | Data-available request |
| irq_err_o | output | 1 | Receive-error request |
| irq_brk_o | output | 1 | Break/overrun request |

## Verification
The bench sends a character into a full queue, then keeps sending while the overrun flag stays set after reads have made room. A design that checked only for space would take in the second character. It sends an all-zero frame and the characters after it. A design that ignored the pending break would queue that data, and one that did not recognise the frame would queue a zero byte. It puts a 0 in the second stop bit, sends a short low glitch, and sends bad parity and bad stop bits. A design that checked both stop bits, treated the glitch as a start, or dropped flawed characters would show the wrong flags or the wrong queue count on the very cycle the stop bit is sampled.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    localparam int OS_W     = 4;
    localparam int OS_MID   = 7;
    localparam int OS_LAST  = 15;
endpackage

// File: rtl/srx_baud_tick.sv
module srx_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              parity_en_i,
    input  logic              parity_odd_i,
    input  logic              two_stop_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              break_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_t         state_q, state_d;
    logic [OS_W-1:0]   os_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic              mid_pt, bit_end;

    assign mid_pt  = tick_i && (os_q == OS_W'(OS_MID));
    assign bit_end = tick_i && (os_q == OS_W'(OS_LAST));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick_i && !rx_i) state_d = ST_START;
            ST_START:  if (mid_pt) state_d = rx_i ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_end && idx_q == IW'(DATA_W-1))
                           state_d = parity_en_i ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_end) state_d = ST_STOP1;
            ST_STOP1:  if (bit_end) state_d = two_stop_i ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // bit timing and assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q    <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
        end else if (tick_i) begin
            if (state_q == ST_IDLE || (state_q == ST_START && mid_pt))
                os_q <= '0;
            else
                os_q <= os_q + 1'b1;
            if (state_q == ST_START)
                idx_q <= '0;
            if (state_q == ST_DATA && bit_end) begin
                shift_q <= {rx_i, shift_q[DATA_W-1:1]};
                idx_q   <= idx_q + 1'b1;
            end
            if (state_q == ST_PARITY && bit_end)
                par_q <= rx_i;
        end
    end

    // outputs, meaningful while done_o is high
    always_comb begin
        done_o       = (state_q == ST_STOP1) && bit_end;
        data_o       = shift_q;
        frame_err_o  = !rx_i;
        parity_err_o = parity_en_i && (par_q != ((^shift_q) ^ parity_odd_i));
        break_o      = (shift_q == '0) && (!parity_en_i || !par_q) && !rx_i;
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [WIDTH-1:0]         wdata_i,
    input  logic                     pop_i,
    output logic [WIDTH-1:0]         rdata_o,
    output logic [$clog2(DEPTH):0]   count_o,
    output logic                     full_o,
    output logic                     empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem_q[rp_q];
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8,
    parameter int RX_THRESH  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_i,
    input  logic [DIV_W-1:0]            baud_div_i,
    input  logic                        parity_en_i,
    input  logic                        parity_odd_i,
    input  logic                        two_stop_i,
    input  logic                        rx_irq_en_i,
    input  logic                        err_irq_en_i,
    input  logic                        rd_en_i,
    input  logic                        clr_err_i,
    input  logic                        clr_ovr_i,
    input  logic                        clr_brk_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic [$clog2(FIFO_DEPTH):0] fifo_count_o,
    output logic                        data_ready_o,
    output logic                        thresh_o,
    output logic                        framing_err_o,
    output logic                        parity_err_o,
    output logic                        overrun_o,
    output logic                        break_o
    ,
    output logic                        irq_rx_o,
    output logic                        irq_err_o,
    output logic                        irq_brk_o
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic              tick;
    logic [1:0]        sync_q;
    logic              done, f_err, p_err, brk_frame;
    logic [DATA_W-1:0] char_data;
    logic              q_full, q_empty, store;
    logic              fer_q, per_q, ovr_q, brk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    srx_baud_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .tick_o(tick)
    );

    srx_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(sync_q[1]),
        .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
        .two_stop_i(two_stop_i), .done_o(done), .data_o(char_data),
        .frame_err_o(f_err), .parity_err_o(p_err), .break_o(brk_frame)
    );

    assign store = done && !q_full && !ovr_q && !brk_q && !brk_frame;

    srx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(store), .wdata_i(char_data),
        .pop_i(rd_en_i), .rdata_o(rd_data_o), .count_o(fifo_count_o),
        .full_o(q_full), .empty_o(q_empty)
    );

    // sticky flags: a set in the same cycle wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fer_q <= 1'b0;
            per_q <= 1'b0;
            ovr_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            if (done && f_err)                      fer_q <= 1'b1;
            else if (clr_err_i)                     fer_q <= 1'b0;
            if (done && p_err)                      per_q <= 1'b1;
            else if (clr_err_i)                     per_q <= 1'b0;
            if (done && q_full && !brk_frame)       ovr_q <= 1'b1;
            else if (clr_ovr_i)                     ovr_q <= 1'b0;
            if (done && brk_frame)                  brk_q <= 1'b1;
            else if (clr_brk_i)                     brk_q <= 1'b0;
        end
    end

    always_comb begin
        framing_err_o = fer_q;
        parity_err_o  = per_q;
        overrun_o     = ovr_q;
        break_o       = brk_q;
        data_ready_o  = !q_empty;
        thresh_o      = (fifo_count_o >= CW'(RX_THRESH));
        irq_rx_o      = rx_irq_en_i && (thresh_o || data_ready_o);
        irq_err_o     = (rx_irq_en_i || err_irq_en_i) && (fer_q || per_q);
        irq_brk_o     = (rx_irq_en_i || err_irq_en_i) && (brk_q || ovr_q);
    end
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
    parameter int FIFO_DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_en_i,
    input logic                        clr_err_i,
    input logic                        clr_ovr_i,
    input logic                        clr_brk_i,
    input logic                        rx_irq_en_i,
    input logic                        err_irq_en_i,
    input logic [$clog2(FIFO_DEPTH):0] fifo_count_o,
    input logic                        framing_err_o,
    input logic                        parity_err_o,
    input logic                        overrun_o,
    input logic                        break_o,
    input logic                        irq_brk_o
);
    a_r13_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count_o != $past(fifo_count_o)) |->
        ((fifo_count_o == $past(fifo_count_o) + 1'b1) ||
         (fifo_count_o == $past(fifo_count_o) - 1'b1)));

    a_r7_ovr_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(fifo_count_o) == ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH)));

    a_r8_ovr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> (fifo_count_o <= $past(fifo_count_o)));

    a_r9_brk_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |=> (fifo_count_o <= $past(fifo_count_o)));

    a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (break_o && !clr_brk_i) |=> break_o);

    a_r14_fer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (framing_err_o && !clr_err_i) |=> framing_err_o);

    a_r14_per_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err_o && !clr_err_i) |=> parity_err_o);

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !clr_ovr_i) |=> overrun_o);

    a_r12_brk_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(break_o) && (rx_irq_en_i || err_irq_en_i)) |-> irq_brk_o);

    a_r13_no_pop_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (fifo_count_o >= $past(fifo_count_o)));
endmodule

bind serial_rx_core serial_rx_core_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .clr_err_i(clr_err_i),
    .clr_ovr_i(clr_ovr_i), .clr_brk_i(clr_brk_i), .rx_irq_en_i(rx_irq_en_i),
    .err_irq_en_i(err_irq_en_i), .fifo_count_o(fifo_count_o),
    .framing_err_o(framing_err_o), .parity_err_o(parity_err_o),
    .overrun_o(overrun_o), .break_o(break_o), .irq_brk_o(irq_brk_o)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
    localparam int DW = 8;
    localparam int DEPTH = 4;
    localparam int THR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic [7:0] bdiv = 8'd0;
    logic pen = 1'b0, podd = 1'b0, two_stop = 1'b0;
    logic rie = 1'b0, reie = 1'b0, rd_en = 1'b0;
    logic clr_err = 1'b0, clr_ovr = 1'b0, clr_brk = 1'b0;
    logic [DW-1:0] rd_data;
    logic [$clog2(DEPTH):0] cnt;
    logic dready, thr, fer, per, ovr, brk, irq_rx, irq_err, irq_brk;

    always #2.5 clk = ~clk;

    serial_rx_core #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .DIV_W(8), .RX_THRESH(THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(bdiv),
        .parity_en_i(pen), .parity_odd_i(podd), .two_stop_i(two_stop),
        .rx_irq_en_i(rie), .err_irq_en_i(reie), .rd_en_i(rd_en),
        .clr_err_i(clr_err), .clr_ovr_i(clr_ovr), .clr_brk_i(clr_brk),
        .rd_data_o(rd_data), .fifo_count_o(cnt), .data_ready_o(dready),
        .thresh_o(thr), .framing_err_o(fer), .parity_err_o(per),
        .overrun_o(ovr), .break_o(brk), .irq_rx_o(irq_rx),
        .irq_err_o(irq_err), .irq_brk_o(irq_brk)
    );

    // behavioural reference state
    logic [DW-1:0] mq[$];
    bit m_fer, m_per, m_ovr, m_brk;
    bit cmp_en = 0;
    int n_cmp = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int sz = mq.size();
        bit en_any = rie || reie;
        chk(cnt == sz, "R13/R7 queue count", int'(cnt), sz);
        if (sz > 0) chk(rd_data == mq[0], "R2 oldest data", int'(rd_data), int'(mq[0]));
        chk(dready == (sz > 0), "R10 data_ready", int'(dready), int'(sz > 0));
        chk(thr == (sz >= THR), "R10 thresh", int'(thr), int'(sz >= THR));
        chk(fer == m_fer, "R5/R14 framing_err", int'(fer), int'(m_fer));
        chk(per == m_per, "R4/R14 parity_err", int'(per), int'(m_per));
        chk(ovr == m_ovr, "R7/R8 overrun", int'(ovr), int'(m_ovr));
        chk(brk == m_brk, "R9 break", int'(brk), int'(m_brk));
        chk(irq_rx == (rie && (sz >= THR || sz > 0)), "R10 irq_rx", int'(irq_rx),
            int'(rie && (sz >= THR || sz > 0)));
        chk(irq_err == (en_any && (m_fer || m_per)), "R11 irq_err", int'(irq_err),
            int'(en_any && (m_fer || m_per)));
        chk(irq_brk == (en_any && (m_brk || m_ovr)), "R12 irq_brk", int'(irq_brk),
            int'(en_any && (m_brk || m_ovr)));
    endtask

    always @(posedge clk) begin
        #2;
        if (cmp_en) compare_all();
    end

    task automatic model_frame(input logic [DW-1:0] d, input bit pbit, input bit stop);
        bit f  = !stop;
        bit p  = pen && (pbit != ((^d) ^ podd));
        bit bf = (d == '0) && (!pen || !pbit) && !stop;
        bit full = (mq.size() == DEPTH);
        if (!full && !m_ovr && !m_brk && !bf) mq.push_back(d);
        if (full && !bf) m_ovr = 1;
        if (bf) m_brk = 1;
        if (f)  m_fer = 1;
        if (p)  m_per = 1;
    endtask

    // sends start, data LSB first, optional parity, stop(s); cpb clocks per bit
    task automatic send(input logic [DW-1:0] d, input bit bad_par, input bit stop,
                        input bit stop2, input int cpb);
        bit bits[$];
        bit pbit = ((^d) ^ podd) ^ bad_par;
        int sidx;
        bits.push_back(1'b0);
        for (int k = 0; k < DW; k++) bits.push_back(d[k]);
        if (pen) bits.push_back(pbit);
        sidx = bits.size();
        bits.push_back(stop);
        if (two_stop) bits.push_back(stop2);
        @(negedge clk);
        for (int n = 0; n < bits.size() * cpb; n++) begin
            rx = bits[n / cpb];
            if (cpb == 16 && n == 16 * sidx + 10) model_frame(d, pbit, stop);
            @(negedge clk);
        end
        rx = 1'b1;
        if (cpb != 16) model_frame(d, pbit, stop);
        repeat (24) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        if (mq.size() > 0) void'(mq.pop_front());
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clr(input int which);
        @(negedge clk);
        if (which == 0) begin clr_err = 1'b1; m_fer = 0; m_per = 0; end
        if (which == 1) begin clr_ovr = 1'b1; m_ovr = 0; end
        if (which == 2) begin clr_brk = 1'b1; m_brk = 0; end
        @(negedge clk);
        clr_err = 1'b0; clr_ovr = 1'b0; clr_brk = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;                 // R1: reset state compared from here
        repeat (4) @(negedge clk);
        rie = 1'b1;
        // R2 plain character, no parity
        send(8'hA5, 0, 1, 1, 16);
        // R4 even parity good and bad (bad still stored)
        pen = 1'b1;
        send(8'h3C, 0, 1, 1, 16);
        send(8'h71, 1, 1, 1, 16);
        // R4 odd parity good
        podd = 1'b1;
        send(8'hE2, 0, 1, 1, 16);
        // R7 queue full: overrun, discarded
        send(8'h5A, 0, 1, 1, 16);
        // R13 reads
        pop(); pop();
        // R8 overrun pending blocks with room
        send(8'h0F, 0, 1, 1, 16);
        pulse_clr(1);
        send(8'hC3, 0, 1, 1, 16);
        // R14 clear errors, R5 stop error stored
        pulse_clr(0);
        pen = 1'b0;
        send(8'h81, 0, 0, 1, 16);
        pop(); pop(); pop(); pop();
        pop();                      // R13 read of empty queue
        pulse_clr(0);
        // R6 two stop bits, second at 0 not checked
        two_stop = 1'b1;
        send(8'h96, 0, 1, 0, 16);
        two_stop = 1'b0;
        // R3 glitch shorter than half a bit
        @(negedge clk); rx = 1'b0;
        repeat (4) @(negedge clk); rx = 1'b1;
        repeat (40) @(negedge clk);
        // R9 break with only error enable, R11/R12 enables
        rie = 1'b0; reie = 1'b1;
        send(8'h00, 0, 0, 1, 16);
        send(8'h44, 0, 1, 1, 16);   // blocked by pending break
        pulse_clr(2);
        pulse_clr(0);
        send(8'h44, 0, 1, 1, 16);
        reie = 1'b0;
        repeat (4) @(negedge clk);
        rie = 1'b1;
        // R2 divider: tick every 2 clocks, 32 clocks per bit
        pop(); pop();
        cmp_en = 0;
        bdiv = 8'd1;
        send(8'h6B, 0, 1, 1, 32);
        bdiv = 8'd0;
        repeat (4) @(negedge clk);
        cmp_en = 1;
        repeat (4) @(negedge clk);
        pop();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule